// File: doc/BRIEF.md
# Keyed Software Watchdog

The block is a software watchdog. A byte-wide protection register configures it, and it accepts only the first write after reset. A free-running counter advances on a clock-enable input, with an optional extra prescale stage. The counter restarts only when software writes an ordered two-byte key to a separate service address. If the counter reaches the selected terminal count first, the block issues a single-cycle reset request. It also sets a sticky watchdog bit in a reset-cause status byte.

The protection byte also carries the halt-monitor enable, the bus-monitor external enable and the bus-monitor timing fields. The block stores these fields and returns them on the configuration readback, but no logic in the block acts on them. Writes arrive on a simple synchronous port made of a strobe, a byte address and a data byte.

Top module: `swdog_keyed`

## Requirements
- R1: After rst_ni is asserted, rst_req_o is 0, cfg_o is 8'h00 and status_o is 8'h00.
- R2: The first write to address 0 (the protection register) after reset is stored and shown on cfg_o the cycle after the write edge. Every later write to address 0 is ignored until the next reset.
- R3: The protection byte has these fields: bit 7 enables the watchdog, bit 6 selects the prescaler, and bits 5:4 select the timeout. Bits 3:0 (halt-monitor enable at bit 3, bus-monitor external enable at bit 2, bus-monitor timing at bits 1:0) are stored and read back on cfg_o without effect.
- R4: The counter advances only on cycles with tick_i high. With the prescaler off, the timeout select value s gives a terminal count of 2^(9+2s) ticks. With tick_i held high, rst_req_o rises exactly 2^(9+2s) clock edges after the last reload.
- R5: With bit 6 set, the counter advances once per PRE_DIV ticks (default 512), so the timeout is multiplied by PRE_DIV.
- R6: Writing 8'h55 and then 8'hAA to address 1 (the service register) reloads the counter to zero on the 8'hAA write edge.
- R7: Any other value written to address 1 after 8'h55 disarms the key. A following 8'hAA, and any 8'hAA not preceded by 8'h55, has no effect on the timeout.
- R8: While bit 7 is clear, the counter is held at zero and rst_req_o stays low.
- R9: rst_req_o is high for exactly one cycle per timeout. The counter restarts from zero on the same edge, so the next request follows one terminal count later.
- R10: A timeout sets status_o bit 5. The bit stays set until rst_ni, and all other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register byte address (0 protection, 1 service) |
| wr_data_i | input | 8 | Write data byte |
| tick_i | input | 1 | Prescaled count enable |
| rst_req_o | output | 1 | Single-cycle reset request on timeout |
| cfg_o | output | 8 | Protection register readback |
| status_o | output | 8 | Reset-cause byte, bit 5 set by watchdog timeout |

## Verification
The configuration readback and the status bit are registered, so each is due one edge after the write or the timeout that causes it. The reset request is due exactly the terminal count of edges after the reload edge: the configuring write, the 0xAA write, or the previous request. The bench counts falling edges from the reload edge and compares that count with 2^(9+2s), multiplied by the prescale factor when bit 6 is set. It samples only at falling edges, so each check reads the state settled after the preceding rising edge.

// File: rtl/swdog_pkg.sv
package swdog_pkg;
  typedef struct packed {
    logic       wd_en;
    logic       pre_sel;
    logic [1:0] tmo_sel;
    logic       halt_en;
    logic       bus_ext_en;
    logic [1:0] bus_tmo;
  } prot_cfg_t;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam int         STAT_WD_BIT = 5;
endpackage

// File: rtl/swdog_cfg_reg.sv
module swdog_cfg_reg
  import swdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output prot_cfg_t  cfg_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '0;
      locked_q <= 1'b0;
    end else if (wr_i && !locked_q) begin
      cfg_o    <= prot_cfg_t'(data_i);
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/swdog_key.sv
module swdog_key
  import swdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       service_o
);
  logic armed_q;

  assign service_o = wr_i && armed_q && (data_i == KEY_FIRE);

  // any service write other than the arm key disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == KEY_ARM);
  end
endmodule

// File: rtl/swdog_count.sv
module swdog_count #(
  parameter int BASE_EXP = 9,
  parameter int EXP_STEP = 2,
  parameter int SEL_W    = 2,
  parameter int PRE_DIV  = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pre_sel_i,
  input  logic [SEL_W-1:0] tmo_sel_i,
  input  logic             tick_i,
  input  logic             service_i,
  output logic             expire_o
);
  localparam int N_SEL   = 1 << SEL_W;
  localparam int MAX_EXP = BASE_EXP + EXP_STEP * (N_SEL - 1);
  localparam int CNT_W   = MAX_EXP;
  localparam int PRE_W   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [CNT_W-1:0] last_cnt [N_SEL];
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             step;
  logic             at_end;

  for (genvar g = 0; g < N_SEL; g++) begin : g_term
    assign last_cnt[g] = CNT_W'((64'd1 << (BASE_EXP + EXP_STEP * g)) - 64'd1);
  end

  assign step   = tick_i && (!pre_sel_i || (pre_q == PRE_LAST));
  assign at_end = (cnt_q == last_cnt[tmo_sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (!en_i || service_i) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick_i) begin
        pre_q <= (!pre_sel_i || pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        if (step) begin
          if (at_end) begin
            cnt_q    <= '0;
            expire_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/swdog_keyed.sv
module swdog_keyed
  import swdog_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 0,
  parameter int KEY_ADDR = 1,
  parameter int BASE_EXP = 9,
  parameter int PRE_DIV  = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              tick_i,
  output logic              rst_req_o,
  output logic [7:0]        cfg_o,
  output logic [7:0]        status_o
);
  prot_cfg_t cfg;
  logic      cfg_wr, key_wr, service, expire;
  logic      wd_cause_q;

  assign cfg_wr = wr_en_i && (wr_addr_i == ADDR_W'(CFG_ADDR));
  assign key_wr = wr_en_i && (wr_addr_i == ADDR_W'(KEY_ADDR));

  swdog_cfg_reg u_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr), .data_i(wr_data_i), .cfg_o(cfg)
  );

  swdog_key u_key (
    .clk_i (clk_i), .rst_ni(rst_ni), .wr_i(key_wr), .data_i(wr_data_i), .service_o(service)
  );

  swdog_count #(
    .BASE_EXP(BASE_EXP), .EXP_STEP(2), .SEL_W(2), .PRE_DIV(PRE_DIV)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg.wd_en),
    .pre_sel_i(cfg.pre_sel),
    .tmo_sel_i(cfg.tmo_sel),
    .tick_i   (tick_i),
    .service_i(service),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wd_cause_q <= 1'b0;
    else if (expire) wd_cause_q <= 1'b1;
  end

  assign rst_req_o = expire;
  assign cfg_o     = cfg;
  always_comb begin
    status_o              = '0;
    status_o[STAT_WD_BIT] = wd_cause_q;
  end
endmodule

// File: rtl/swdog_keyed_chk.sv
module swdog_keyed_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_req_o,
  input logic [7:0] cfg_o,
  input logic [7:0] status_o
);
  logic [7:0] cfg_prev;
  logic       cfg_changed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_prev    <= '0;
      cfg_changed <= 1'b0;
    end else begin
      cfg_prev <= cfg_o;
      if (cfg_o != cfg_prev) cfg_changed <= 1'b1;
    end
  end

  assert_cfg_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o != cfg_prev) |-> !cfg_changed);

  assert_off_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[7] |=> !rst_req_o);

  assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_cause_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> status_o[5]);

  assert_cause_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] |=> status_o[5]);

  assert_status_other_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & 8'hDF) == 8'h00);
endmodule

bind swdog_keyed swdog_keyed_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rst_req_o(rst_req_o),
  .cfg_o    (cfg_o),
  .status_o (status_o)
);

// File: tb/swdog_keyed_bench.sv
module swdog_keyed_bench;
  localparam int PRE = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       tick_i = 1'b1;
  logic       rst_req_o;
  logic [7:0] cfg_o, status_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  swdog_keyed #(.PRE_DIV(PRE)) u_swdog_keyed (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tick_i(tick_i), .rst_req_o(rst_req_o),
    .cfg_o(cfg_o), .status_o(status_o)
  );

  // {config byte, expected edges to first request}
  localparam logic [31:0] VEC [6] = '{
    {8'h80, 24'd512}, {8'h90, 24'd2048}, {8'hA0, 24'd8192},
    {8'hB0, 24'd32768}, {8'hC0, 24'd2048}, {8'hD0, 24'd8192}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 1'b1; wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  // falling edges after the reload edge until rst_req_o seen; -1 if none
  task automatic measure(input int limit, output int n);
    n = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk_i);
      if (rst_req_o) begin n = k; break; end
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    #1;
    check("R1 rst_req", int'(rst_req_o), 0);
    check("R1 cfg", int'(cfg_o), 0);
    check("R1 status", int'(status_o), 0);
    do_reset();

    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(4'd0, VEC[i][31:24]);
      measure(40000, n);
      check("R4/R5 first timeout", n, int'(VEC[i][23:0]));
      @(negedge clk_i);
      check("R9 single cycle", int'(rst_req_o), 0);
      check("R10 cause", int'(status_o), 8'h20);
      if (i < 2) begin
        measure(40000, n);
        check("R9 restart", n, int'(VEC[i][23:0]) - 2);
      end
    end

    // R2 write-once, R3 monitor bits read back
    do_reset();
    wr(4'd0, 8'h0F);
    @(negedge clk_i);
    check("R3 readback", int'(cfg_o), 8'h0F);
    wr(4'd0, 8'h80);
    @(negedge clk_i);
    check("R2 second write ignored", int'(cfg_o), 8'h0F);
    measure(2000, n);
    check("R8 disabled no request", n, -1);
    check("R8 no cause", int'(status_o), 0);

    // R6 valid key reloads
    do_reset();
    wr(4'd0, 8'h80);
    repeat (300) @(negedge clk_i);
    wr(4'd1, 8'h55);
    wr(4'd1, 8'hAA);
    measure(2000, n);
    check("R6 service reload", n, 512);

    // R7 interrupted key
    do_reset();
    wr(4'd0, 8'h80);
    repeat (100) @(negedge clk_i);
    wr(4'd1, 8'h55);
    wr(4'd1, 8'h12);
    wr(4'd1, 8'hAA);
    measure(2000, n);
    check("R7 broken key", n, 409);

    // R7 lone fire key
    do_reset();
    wr(4'd0, 8'h80);
    repeat (100) @(negedge clk_i);
    wr(4'd1, 8'hAA);
    wr(4'd1, 8'hAA);
    measure(2000, n);
    check("R7 unarmed key", n, 410);

    // R4 tick gating
    do_reset();
    tick_i = 1'b0;
    wr(4'd0, 8'h80);
    measure(1000, n);
    check("R4 no tick no request", n, -1);
    tick_i = 1'b1;
    measure(2000, n);
    check("R4 count resumes", n, 511);

    // R1 reset clears cause and config
    do_reset();
    @(negedge clk_i);
    check("R1 cause cleared", int'(status_o), 0);
    check("R1 cfg cleared", int'(cfg_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule